// File: doc/BRIEF.md
# PCIe memory request header generator

This block assembles the header of a PCIe memory read or memory write request and streams it out one 32-bit dword per beat over a valid/ready handshake. A request is launched with a one-cycle start pulse. The same cycle presents a 64-bit bus address, a dword count, a read/write select and the 16-bit identity of the requester. The block registers these values, so the request source may change its inputs as soon as the start has been taken.

The header form depends on the address of each request. If the upper half of the address is zero, the block sends the short 3-dword header, which carries only the low 32 address bits. If the upper half is non-zero, it sends the long 4-dword header, which carries the full address. The block also owns the 8-bit request tag. The tag advances once per completed header, so that requests in flight can be told apart. The payload of a write follows the header and is produced elsewhere. The downstream consumer uses the last-beat flag to find where the header ends.

Top module: `pcie_mreq_hdr_gen`

## Requirements
- R1: When address bits 63:32 are all zero, the header has 3 dwords and dword 2 holds the low address word. Otherwise the header has 4 dwords, dword 2 holds address bits 63:32 and dword 3 holds the low address word.
- R2: Dword 0 bits 31:29 are {0, write, long-form}. Bits 28:24 (the type) are 00000. Bits 23:10 (traffic class, attributes, hints, digest, poison, translation) are all zero.
- R3: Dword 0 bits 9:0 carry the dword count exactly as given. A count of 0 is sent as 0, which encodes 1024 dwords.
- R4: Dword 1 holds the requester ID in bits 31:16, the tag in bits 15:8, the last-dword byte enable in bits 7:4 and the first-dword byte enable in bits 3:0. A count of 1 gives enables 0000 (last) and 1111 (first). Any other count gives 1111 for both.
- R5: Address bits 1:0 are always sent as zero in the low address word.
- R6: The tag is 0 after reset and increases by one, modulo 256, after the last beat of each header is accepted.
- R7: A beat is consumed only on a cycle where valid and ready are both high. While valid is high and ready is low, the data and the last flag hold their values.
- R8: The last flag is high on the final header dword and low on every other beat.
- R9: A start pulse seen while a header is in progress is ignored: no extra header is produced and the header in flight is unchanged.
- R10: Valid is low after reset and rises in the cycle that follows the clock edge which sampled the start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch a request (taken only when idle) |
| addr_i | input | 64 | Target bus address |
| len_i | input | 10 | Transfer length in dwords, 0 meaning 1024 |
| wr_i | input | 1 | 1 for memory write, 0 for memory read |
| req_id_i | input | 16 | Requester ID placed in dword 1 |
| m_valid_o | output | 1 | Header dword valid |
| m_ready_i | input | 1 | Downstream can take the dword |
| m_data_o | output | 32 | Header dword |
| m_last_o | output | 1 | Final dword of the header |

## Verification
A wrong choice of header form shows at the ports within the first beat, as the long-form bit in dword 0. At the end of the header it shows again, because the last flag lands one beat early or late. A beat index that slips under back-pressure repeats or skips a dword. The scoreboard sees this on the next accepted beat. A tag counter that fails to advance, or advances twice, shows in dword 1 of the next request. The bench runs past 256 requests so that the wrap is visible. A start pulse that is wrongly accepted while busy corrupts the header in flight, or produces valid beats after the queue of expected beats is empty, within a cycle of the header finishing.

// File: rtl/mreq_hdr_pkg.sv
package mreq_hdr_pkg;
   localparam int DW_W        = 32;
   localparam int ADDR_W      = 64;
   localparam int LEN_W       = 10;
   localparam int RID_W       = 16;
   localparam int TAG_FIELD_W = 8;
   localparam int BE_W        = 4;
   localparam int MAX_HDR_DW  = 4;
   localparam int IDX_W       = $clog2(MAX_HDR_DW);
   localparam int RSVD_W      = 14;

   localparam logic [4:0] TYPE_MEM = 5'b00000;

   typedef logic [DW_W-1:0] dword_t;

   typedef struct packed {
      logic [ADDR_W-1:0] addr;
      logic [LEN_W-1:0]  len;
      logic              wr;
      logic [RID_W-1:0]  rid;
   } mreq_t;
endpackage

// File: rtl/mreq_hdr_build.sv
module mreq_hdr_build
   import mreq_hdr_pkg::*;
#(
   parameter int TAG_W = 8
) (
   input  mreq_t                          req_i,
   input  logic [TAG_W-1:0]               tag_i,
   output logic [MAX_HDR_DW-1:0][DW_W-1:0] hdr_o,
   output logic                           long_o
);
   localparam int HALF_W = ADDR_W / 2;

   logic [TAG_FIELD_W-1:0] tag_f;
   logic [BE_W-1:0]        be_last;
   logic [DW_W-1:0]        addr_lo;
   logic [2:0]             fmt;

   generate
      if (TAG_W == TAG_FIELD_W) begin : g_tag_full
         assign tag_f = tag_i;
      end else begin : g_tag_pad
         assign tag_f = {{(TAG_FIELD_W-TAG_W){1'b0}}, tag_i};
      end
   endgenerate

   always_comb begin
      long_o   = |req_i.addr[ADDR_W-1:HALF_W];
      fmt      = {1'b0, req_i.wr, long_o};
      be_last  = (req_i.len == LEN_W'(1)) ? '0 : '1;
      addr_lo  = {req_i.addr[HALF_W-1:2], 2'b00};
      hdr_o[0] = {fmt, TYPE_MEM, {RSVD_W{1'b0}}, req_i.len};
      hdr_o[1] = {req_i.rid, tag_f, be_last, {BE_W{1'b1}}};
      hdr_o[2] = long_o ? req_i.addr[ADDR_W-1:HALF_W] : addr_lo;
      hdr_o[3] = addr_lo;
   end
endmodule

// File: rtl/mreq_tag_ctr.sv
module mreq_tag_ctr #(
   parameter int TAG_W     = 8,
   parameter int TAG_RESET = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   output logic [TAG_W-1:0] tag_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tag_o <= TAG_W'(TAG_RESET);
      end else if (step_i) begin
         tag_o <= tag_o + 1'b1;
      end
   end
endmodule

// File: rtl/mreq_beat_seq.sv
module mreq_beat_seq
   import mreq_hdr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             long_i,
   input  logic             ready_i,
   output logic             valid_o,
   output logic             last_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             load_o,
   output logic             done_o
);
   logic [IDX_W-1:0] final_idx;
   logic             take;

   always_comb begin
      final_idx = long_i ? IDX_W'(MAX_HDR_DW - 1) : IDX_W'(MAX_HDR_DW - 2);
      load_o    = start_i && !valid_o;
      last_o    = valid_o && (idx_o == final_idx);
      take      = valid_o && ready_i;
      done_o    = take && last_o;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         idx_o   <= '0;
      end else if (load_o) begin
         valid_o <= 1'b1;
         idx_o   <= '0;
      end else if (take) begin
         if (last_o) begin
            valid_o <= 1'b0;
            idx_o   <= '0;
         end else begin
            idx_o   <= idx_o + 1'b1;
         end
      end
   end
endmodule

// File: rtl/pcie_mreq_hdr_gen.sv
module pcie_mreq_hdr_gen
   import mreq_hdr_pkg::*;
#(
   parameter int TAG_W     = 8,
   parameter int TAG_RESET = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [63:0]       addr_i,
   input  logic [9:0]        len_i,
   input  logic              wr_i,
   input  logic [15:0]       req_id_i,
   output logic              m_valid_o,
   input  logic              m_ready_i,
   output logic [31:0]       m_data_o,
   output logic              m_last_o
);
   generate
      if (TAG_W < 1 || TAG_W > TAG_FIELD_W) begin : g_bad_tag_w
         $error("TAG_W must lie in 1..8");
      end
      if (TAG_RESET < 0 || TAG_RESET >= (1 << TAG_W)) begin : g_bad_tag_rst
         $error("TAG_RESET must fit in TAG_W bits");
      end
   endgenerate

   mreq_t                           req_q;
   logic [TAG_W-1:0]                tag;
   logic [MAX_HDR_DW-1:0][DW_W-1:0] hdr;
   logic                            long_form;
   logic [IDX_W-1:0]                idx;
   logic                            load;
   logic                            done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q <= '0;
      end else if (load) begin
         req_q <= '{addr: addr_i, len: len_i, wr: wr_i, rid: req_id_i};
      end
   end

   mreq_beat_seq i_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .long_i  (long_form),
      .ready_i (m_ready_i),
      .valid_o (m_valid_o),
      .last_o  (m_last_o),
      .idx_o   (idx),
      .load_o  (load),
      .done_o  (done)
   );

   mreq_tag_ctr #(.TAG_W(TAG_W), .TAG_RESET(TAG_RESET)) i_tag (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (done),
      .tag_o  (tag)
   );

   mreq_hdr_build #(.TAG_W(TAG_W)) i_build (
      .req_i  (req_q),
      .tag_i  (tag),
      .hdr_o  (hdr),
      .long_o (long_form)
   );

   assign m_data_o = hdr[idx];
endmodule

// File: rtl/mreq_hdr_chk.sv
module mreq_hdr_chk #(
   parameter int TAG_W = 8
) (
   input logic        clk,
   input logic        rst_n,
   input logic        m_valid_o,
   input logic        m_ready_i,
   input logic [31:0] m_data_o,
   input logic        m_last_o
);
   logic [1:0]       cnt;
   logic             long_q;
   logic [TAG_W-1:0] prev_tag;
   logic             have_prev;
   logic             acc;

   assign acc = m_valid_o && m_ready_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt       <= '0;
         long_q    <= 1'b0;
         prev_tag  <= '0;
         have_prev <= 1'b0;
      end else if (acc) begin
         cnt <= m_last_o ? 2'd0 : cnt + 2'd1;
         if (cnt == 2'd0) long_q <= m_data_o[29];
         if (cnt == 2'd1) begin
            prev_tag  <= m_data_o[8 +: TAG_W];
            have_prev <= 1'b1;
         end
      end
   end

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid_o && !m_ready_i |=> m_valid_o && $stable(m_data_o) && $stable(m_last_o)); // R7

   AST_LAST_POS: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid_o && m_last_o |-> cnt == (long_q ? 2'd3 : 2'd2)); // R1

   AST_NO_EARLY_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid_o && cnt < 2'd2 |-> !m_last_o); // R8

   AST_DW0_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid_o && cnt == 2'd0 |-> !m_data_o[31] && m_data_o[28:10] == '0); // R2

   AST_ADDR_LSB: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid_o && m_last_o |-> m_data_o[1:0] == 2'b00); // R5

   AST_TAG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid_o && cnt == 2'd1 && have_prev |-> m_data_o[8 +: TAG_W] == TAG_W'(prev_tag + 1'b1)); // R6
endmodule

bind pcie_mreq_hdr_gen mreq_hdr_chk #(.TAG_W(TAG_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .m_valid_o (m_valid_o),
   .m_ready_i (m_ready_i),
   .m_data_o  (m_data_o),
   .m_last_o  (m_last_o)
);

// File: tb/test_pcie_mreq_hdr_gen.sv
module test_pcie_mreq_hdr_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [63:0] addr_i = '0;
   logic [9:0]  len_i = '0;
   logic        wr_i = 1'b0;
   logic [15:0] req_id_i = '0;
   logic        m_valid_o;
   logic        m_ready_i = 1'b1;
   logic [31:0] m_data_o;
   logic        m_last_o;

   int checks = 0;
   int errors = 0;
   int exp_tag = 0;
   int rdy_mode = 0;
   bit finished = 0;
   logic [15:0] lfsr = 16'hACE1;

   logic [32:0] exp_q[$];
   string       exp_r[$];

   always #10 clk = ~clk;

   pcie_mreq_hdr_gen i_pcie_mreq_hdr_gen (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
      .len_i(len_i), .wr_i(wr_i), .req_id_i(req_id_i),
      .m_valid_o(m_valid_o), .m_ready_i(m_ready_i),
      .m_data_o(m_data_o), .m_last_o(m_last_o)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   // ready pattern, changed just after the rising edge
   always @(posedge clk) begin
      #1;
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (rdy_mode)
         0: m_ready_i <= 1'b1;
         1: m_ready_i <= ~m_ready_i;
         default: m_ready_i <= lfsr[0] | lfsr[3];
      endcase
   end

   // monitor: compare each accepted beat with the scoreboard
   always @(negedge clk) begin
      if (rst_n && m_valid_o && m_ready_i) begin
         if (exp_q.size() == 0) begin
            check(0, "R9 unexpected beat", {31'b0, m_last_o, m_data_o}, 64'h0);
         end else begin
            logic [32:0] e;
            string r;
            e = exp_q.pop_front();
            r = exp_r.pop_front();
            check({m_last_o, m_data_o} === e, r, {31'b0, m_last_o, m_data_o}, {31'b0, e});
         end
      end
   end

   task automatic push_expected(input logic [63:0] a, input logic [9:0] len, input bit wr, input logic [15:0] rid);
      bit          lng;
      logic [31:0] lo;
      lng = (a[63:32] != 32'h0);
      lo  = {a[31:2], 2'b00};
      exp_q.push_back({1'b0, 1'b0, wr, lng, 5'b0, 14'b0, len});
      exp_r.push_back("R2/R3 dword0");
      exp_q.push_back({1'b0, rid, 8'(exp_tag), (len == 10'd1) ? 4'h0 : 4'hF, 4'hF});
      exp_r.push_back("R4/R6 dword1");
      if (lng) begin
         exp_q.push_back({1'b0, a[63:32]});
         exp_r.push_back("R1 dword2 high address");
         exp_q.push_back({1'b1, lo});
         exp_r.push_back("R1/R5/R8 dword3 low address");
      end else begin
         exp_q.push_back({1'b1, lo});
         exp_r.push_back("R1/R5/R8 dword2 low address");
      end
      exp_tag = (exp_tag + 1) % 256;
   endtask

   task automatic wait_idle();
      while (exp_q.size() != 0) @(negedge clk);
      @(posedge clk);
      #1;
   endtask

   // issue one request; intrude>0 drives stray starts while busy (R9)
   task automatic issue(input logic [63:0] a, input logic [9:0] len, input bit wr, input logic [15:0] rid, input int intrude);
      wait_idle();
      push_expected(a, len, wr, rid);
      addr_i = a; len_i = len; wr_i = wr; req_id_i = rid; start_i = 1'b1;
      @(posedge clk);
      #1;
      start_i = 1'b0;
      addr_i = ~a; len_i = ~len; wr_i = ~wr; req_id_i = ~rid;
      @(negedge clk);
      check(m_valid_o === 1'b1, "R10 valid after start", {63'b0, m_valid_o}, 64'h1);
      for (int k = 0; k < intrude; k++) begin
         @(posedge clk);
         #1;
         start_i = 1'b1;
         addr_i = 64'hDEAD_0000_0000_0000 + k;
      end
      if (intrude > 0) begin
         @(posedge clk);
         #1;
         start_i = 1'b0;
      end
   endtask

   initial begin
      #(200000 * 20);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(negedge clk);
      check(m_valid_o === 1'b0, "R10 valid low after reset", {63'b0, m_valid_o}, 64'h0);

      // R1 R2 R3 R4 R5: short form read of one dword
      issue(64'h0000_0000_1234_5677, 10'd1, 1'b0, 16'h0100, 0);
      // R1 long form write of 32 dwords
      issue(64'h0000_0001_8000_0042, 10'd32, 1'b1, 16'hBEEF, 0);
      // R3 length 0 (1024 dwords), long form read
      issue(64'hFFFF_FFFF_FFFF_FFFF, 10'd0, 1'b0, 16'h00A5, 0);
      // boundary: only bit 32 set, and all-ones low word
      issue(64'h0000_0001_0000_0000, 10'd2, 1'b1, 16'h7FFF, 0);
      issue(64'h0000_0000_FFFF_FFFF, 10'd1023, 1'b1, 16'h0001, 0);

      // R7: back-pressure patterns
      rdy_mode = 1;
      issue(64'h0000_0002_0000_1000, 10'd1, 1'b0, 16'h1234, 0);
      issue(64'h0000_0000_0000_2000, 10'd4, 1'b1, 16'h4321, 0);
      rdy_mode = 2;
      for (int i = 0; i < 6; i++)
         issue({30'h0, 2'(i), 32'h1000_0000 + 32'(i * 4)}, 10'(i + 1), 1'(i), 16'(i), 0);

      // R9: stray start pulses while busy
      rdy_mode = 1;
      issue(64'h0000_0000_0000_3004, 10'd8, 1'b0, 16'h5555, 2);
      issue(64'h0000_0003_0000_3008, 10'd8, 1'b1, 16'hAAAA, 3);
      wait_idle();
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check(m_valid_o === 1'b0, "R9 no extra header after stray start", {63'b0, m_valid_o}, 64'h0);
      end

      // R6: run the tag through its wrap
      rdy_mode = 0;
      for (int i = 0; i < 250; i++)
         issue((i % 3 == 0) ? 64'h0000_0004_0000_0000 + 64'(i * 4) : 64'(i * 16), 10'(i), 1'(i % 2), 16'(i * 7), 0);

      wait_idle();
      repeat (2) @(negedge clk);
      check(exp_q.size() == 0, "R8 all expected beats seen", 64'(exp_q.size()), 64'h0);
      finished = 1;
      summary();
      $finish;
   end
endmodule